// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Periodic Tick

This block keeps a free-running up-counter of `CNT_W` bits, 16 by default. The counter advances once per prescaled period of the system clock. Software can read the counter but cannot load it or stop it. A separate binary divider runs from the same clock and produces a periodic real-time tick at one of four rates.

Each event owns a sticky flag:
- the counter wrapping from all ones to zero;
- each real-time tick.

Software clears a flag by writing a 1 to its bit. Each flag also has an enable, and an interrupt line is high while both the flag and its enable are set.

Software reaches the block through a simple strobe interface: an address, a write strobe, write data, and read data returned combinationally for the presented address.

| Address | Register | Contents |
|---|---|---|
| 0 | COUNT | Counter value, read-only |
| 1 | CTRL | Configuration fields and enables |
| 2 | FLAGS | Sticky flags, write-one-to-clear |
| 3 | (none) | Reads as zero |

Top module: `prescaled_timer`

## Requirements
- R1: While reset is low, the counter, prescaler, tick divider, flags and enables are zero. A read of COUNT, CTRL or FLAGS returns 0, and both interrupt lines are low.
- R2: The counter changes only at the end of a prescaled period, and it always changes by exactly +1. A write to address 0 does not change the counter value.
- R3: CTRL bits [1:0] select the counter divisor: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 16 system clocks per count.
- R4: A new divisor takes effect at the next prescaler terminal count, so the count already in progress finishes at the old divisor. The change does not reset the counter.
- R5: When the counter wraps from all ones to zero, the overflow flag (FLAGS bit 0) is set on the same clock edge.
- R6: Writing FLAGS with bit 0 set clears the overflow flag. A write with bit 0 at 0 leaves it unchanged.
- R7: If a flag-clearing write and a flag-setting event fall on the same clock edge, the flag is set.
- R8: `irq_ovf` is high exactly while the overflow flag and the overflow enable (CTRL bit 4) are both 1.
- R9: CTRL bits [3:2] select the tick period: code n gives 2^(RTI_LOG2+n) system clocks. With the default RTI_LOG2 = 13, code 00 gives 8192 clocks.
- R10: A tick sets the tick flag (FLAGS bit 1). Writing 1 to bit 1 clears it. `irq_tick` is high exactly while that flag and the tick enable (CTRL bit 5) are both 1.
- R11: CTRL reads back the value last written to its six bits, in the order tick enable [5], overflow enable [4], rate [3:2] and divisor [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 COUNT, 1 CTRL, 2 FLAGS |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_tick | output | 1 | Periodic tick interrupt request |

## Verification
- **Divisor sweep.** The counter is measured under all four divisor codes, plus a repeat of one code. Each measurement samples one clock before and one clock on the expected increment, so any wrong divisor, or a step other than one, is caught.
- **Divisor change mid-count.** The divisor is changed partway through a slow count. This separates a change that waits for the terminal count from one that applies at once or clears the counter.
- **Tick period.** The tick is timed between two consecutive flag sets at every rate code.
- **Flag clearing.** The flags are cleared with zero, with the wrong bit and with the right bit, and once on the exact wrap edge. This tells apart a correct write-one-to-clear flag, a flag that any write clears, and a flag where the clear wins over a simultaneous set.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W    = 16,
  parameter int RTI_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_ovf,
  output logic             irq_tick
);
  localparam int RTI_W = RTI_LOG2 + 3;
  localparam logic [1:0] A_COUNT = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;

  logic [CNT_W-1:0] cnt;
  logic [3:0]       pre_cnt, pre_lim, sel_lim;
  logic [RTI_W-1:0] rti_cnt, rti_mask;
  logic [1:0]       pre_sel, rate_sel;
  logic             ovf_ie, tick_ie, ovf_flag, tick_flag;
  logic             tick_en, ovf_set, rti_set;
  logic             wr_ctrl, clr_ovf, clr_tick;
  logic             unused_wdata;

  always_comb begin
    case (pre_sel)
      2'd0:    sel_lim = 4'd0;
      2'd1:    sel_lim = 4'd3;
      2'd2:    sel_lim = 4'd7;
      default: sel_lim = 4'd15;
    endcase
  end

  assign tick_en  = (pre_cnt == pre_lim);
  assign ovf_set  = tick_en && (&cnt);
  assign rti_mask = {RTI_W{1'b1}} >> (2'd3 - rate_sel);
  assign rti_set  = &(rti_cnt | ~rti_mask);

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign clr_ovf  = wr_en && (addr == A_FLAGS) && wdata[0];
  assign clr_tick = wr_en && (addr == A_FLAGS) && wdata[1];
  assign unused_wdata = ^wdata[CNT_W-1:6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      pre_cnt   <= '0;
      pre_lim   <= '0;
      rti_cnt   <= '0;
      pre_sel   <= '0;
      rate_sel  <= '0;
      ovf_ie    <= 1'b0;
      tick_ie   <= 1'b0;
      ovf_flag  <= 1'b0;
      tick_flag <= 1'b0;
    end else begin
      rti_cnt <= rti_cnt + 1'b1;
      if (tick_en) begin
        cnt     <= cnt + 1'b1;
        pre_cnt <= '0;
        pre_lim <= sel_lim;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (wr_ctrl)
        {tick_ie, ovf_ie, rate_sel, pre_sel} <= wdata[5:0];
      ovf_flag  <= ovf_set | (ovf_flag & ~clr_ovf);
      tick_flag <= rti_set | (tick_flag & ~clr_tick);
    end
  end

  always_comb begin
    case (addr)
      A_COUNT: rdata = cnt;
      A_CTRL:  rdata = CNT_W'({tick_ie, ovf_ie, rate_sel, pre_sel});
      A_FLAGS: rdata = CNT_W'({tick_flag, ovf_flag});
      default: rdata = '0;
    endcase
  end

  assign irq_ovf  = ovf_flag & ovf_ie;
  assign irq_tick = tick_flag & tick_ie;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [1:0]       wbits,
  input logic [CNT_W-1:0] cnt,
  input logic             tick_en,
  input logic             ovf_set,
  input logic             rti_set,
  input logic             ovf_flag,
  input logic             tick_flag
);
  logic clr_o, clr_t;
  assign clr_o = wr_en && (addr == 2'd2) && wbits[0];
  assign clr_t = wr_en && (addr == 2'd2) && wbits[1];

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> cnt == $past(cnt));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == $past(cnt) + 1'b1);
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);
  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o && !ovf_set) |=> !ovf_flag);
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_o) |=> ovf_flag);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && clr_o) |=> ovf_flag);
  p_tick_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rti_set |=> tick_flag);
  p_tick_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_flag && !clr_t) |=> tick_flag);
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbits(wdata[1:0]),
  .cnt(cnt), .tick_en(tick_en), .ovf_set(ovf_set), .rti_set(rti_set),
  .ovf_flag(ovf_flag), .tick_flag(tick_flag)
);

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int W = 8;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq_ovf, irq_tick;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  prescaled_timer #(.CNT_W(W), .RTI_LOG2(L)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_ovf(irq_ovf), .irq_tick(irq_tick));

  // {divisor code, divisor, counts to measure}
  localparam logic [10:0] VEC [5] = '{
    {2'd0, 5'd1,  4'd5},
    {2'd1, 5'd4,  4'd3},
    {2'd2, 5'd8,  4'd2},
    {2'd3, 5'd16, 4'd2},
    {2'd1, 5'd4,  4'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic sync_count();
    logic [W-1:0] a, b;
    rd(2'd0, a);
    b = a;
    while (b == a) begin
      @(negedge clk);
      rd(2'd0, b);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v, c0;
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    rd(2'd0, v); check(v == 0, "R1 count", v, 0);
    rd(2'd1, v); check(v == 0, "R1 ctrl", v, 0);
    rd(2'd2, v); check(v == 0, "R1 flags", v, 0);
    check(!irq_ovf && !irq_tick, "R1 irqs", {irq_ovf, irq_tick}, 0);
    rst_n = 1'b1;

    // R3 divisor table
    for (int i = 0; i < 5; i++) begin
      int dv, k;
      dv = int'(VEC[i][8:4]);
      k  = int'(VEC[i][3:0]);
      wr(2'd1, W'(VEC[i][10:9]));
      sync_count(); sync_count();
      rd(2'd0, c0);
      repeat (dv * k - 1) @(negedge clk);
      rd(2'd0, v); check(v == W'(c0 + k - 1), "R3 before step", v, W'(c0 + k - 1));
      @(negedge clk);
      rd(2'd0, v); check(v == W'(c0 + k), "R3 at step", v, W'(c0 + k));
    end

    // R2 writes to the count address are ignored
    wr(2'd1, 8'h03);
    sync_count(); sync_count();
    rd(2'd0, c0);
    addr = 2'd0; wdata = 8'h5A; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd0, v); check(v == c0, "R2 read-only", v, c0);

    // R4 divisor change waits for terminal count
    sync_count();
    rd(2'd0, c0);
    addr = 2'd1; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (14) @(negedge clk);
    rd(2'd0, v); check(v == c0, "R4 old divisor holds", v, c0);
    @(negedge clk);
    rd(2'd0, v); check(v == W'(c0 + 1), "R4 terminal step", v, W'(c0 + 1));
    @(negedge clk);
    rd(2'd0, v); check(v == W'(c0 + 2), "R4 new divisor", v, W'(c0 + 2));

    // R5 / R8 first wrap
    do_reset();
    wr(2'd1, 8'h10);
    rd(2'd0, v);
    while (v != 8'hFF) begin @(negedge clk); rd(2'd0, v); end
    check(!irq_ovf, "R5 no flag before wrap", irq_ovf, 0);
    @(negedge clk);
    rd(2'd0, v); check(v == 0, "R5 wrapped count", v, 0);
    check(irq_ovf, "R8 irq with enable", irq_ovf, 1);
    rd(2'd2, v); check(v[0], "R5 flag set", v, 1);
    wr(2'd1, 8'h00);
    check(!irq_ovf, "R8 irq masked", irq_ovf, 0);

    // R6 write-one-to-clear
    wr(2'd2, 8'h00);
    rd(2'd2, v); check(v[0], "R6 zero write keeps", v[0], 1);
    wr(2'd2, 8'h02);
    rd(2'd2, v); check(v[0], "R6 other bit keeps", v[0], 1);
    wr(2'd2, 8'h01);
    rd(2'd2, v); check(!v[0], "R6 clear", v[0], 0);

    // R7 set wins over same-edge clear
    rd(2'd0, v);
    while (v != 8'hFF) begin @(negedge clk); rd(2'd0, v); end
    addr = 2'd2; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, v); check(v[0], "R7 set wins", v[0], 1);
    rd(2'd0, v); check(v == 0, "R7 wrap count", v, 0);

    // R9 tick period per rate
    for (int r = 0; r < 4; r++) begin
      wr(2'd1, W'(8'h20 | (r << 2)));
      do begin
        addr = 2'd2; wdata = 8'h02; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; #1;
      end while (irq_tick);
      while (!irq_tick) @(negedge clk);
      addr = 2'd2; wdata = 8'h02; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      n = 1;
      while (!irq_tick) begin @(negedge clk); n++; end
      check(n == (16 << r), "R9 tick period", n, 16 << r);
    end

    // R10 tick flag gating and clear
    wr(2'd1, 8'h00);
    do begin
      addr = 2'd2; wdata = 8'h02; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      rd(2'd2, v);
    end while (v[1]);
    while (!v[1]) begin @(negedge clk); rd(2'd2, v); end
    check(!irq_tick, "R10 irq masked", irq_tick, 0);
    addr = 2'd2; wdata = 8'h02; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, v); check(!v[1], "R10 clear", v[1], 0);

    // R11 control readback
    wr(2'd1, 8'h2D);
    rd(2'd1, v); check(v == 8'h2D, "R11 readback", v, 8'h2D);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule